// File: doc/BRIEF.md
# Silicon Strip Readout Parser

This block sits behind the link receiver of a silicon strip readout board. It takes the raw byte stream of one front end and turns it into 23-bit tagged hit words for the clustering stage further down. Each event starts with two identification bytes. Each is compared with a configured value, and a mismatch is counted without stopping the parse. A chip header follows, then a zero byte, then any number of channel/ADC byte pairs. A 0xC0 marker followed by an event number closes the event.

The chip number taken from the header is classified into a strip type using three configurable number ranges. For every ADC byte, the block looks up a per-chip gain and offset and computes the corrected amplitude, saturating at 255. A one-bit-per-channel bad-channel map can force the amplitude to zero. The gain and offset tables and the bad-channel map are loaded through a single table-write port, and the byte input stalls while a table write is in progress.

Top module: `strip_parser`

## Requirements
- R1: When the first byte of an event differs from `cfg_seq_id`, or the second byte differs from `cfg_det_id`, `err_hdr_cnt` rises by one. In either case the following byte is still taken as the next field: after the second byte, that is the chip header.
- R2: In the chip-header position, a byte below 128 sends the parser back to expecting the first identification byte. A byte of 128 or more gives chip number = byte − 128.
- R3: When the byte after the chip header is not zero, `err_zero_cnt` rises by one and the parser goes back to expecting the first identification byte. The two error counters never move in the same cycle.
- R4: In the address position, a byte of 0..127 is a channel number. The next byte is an ADC value, and accepting it emits a data word with eof = 0, the chip number's low 4 bits and the channel. The parser then returns to the address position.
- R5: The data field of a data word is raw × gain[chip] + offset[chip], clamped to 255.
- R6: The data field is 0 when the bad-channel map bit at address {(chip − 1) mod 16, channel[6:0]} is set. Chip 0 therefore uses map row 15.
- R7: The type field is 01 if the chip number lies within [stereo_lo, stereo_hi], else 10 if within [axial_lo, axial_hi], else 11 if within [z_lo, z_hi], else 00. Bounds are inclusive and checked in that priority order.
- R8: The byte 0xC0 in the address position is followed by an event number. Accepting the event number emits a word with eof = 1, the event number as data, and the current type, new flag, chip and last channel. The parser then expects the first identification byte.
- R9: The new flag is set when the detector-ID byte matches. It is carried in every word and cleared once a data word has been emitted. A mismatching detector-ID byte leaves it unchanged.
- R10: In the address position, a byte above 127 other than 0xC0 returns the parser to the chip-header position.
- R11: The word layout is type[22:21], new[20], eof[19], data[18:11], chip[10:7], channel[6:0].
- R12: `in_ready` is low while `tbl_we` is high, and no byte is consumed then. A word is valid for one cycle, in the cycle after its last byte is accepted. After reset, both counters are zero and `out_valid` is low.
- R13: Table writes with `tbl_sel` 0 set gain[addr[3:0]], with 1 set offset[addr[3:0]], and with 2 set map bit addr[10:0] to wdata[0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input byte present |
| in_byte | input | 8 | Stream byte |
| in_ready | output | 1 | Byte is accepted when high together with in_valid |
| cfg_seq_id | input | 8 | Expected first identification byte |
| cfg_det_id | input | 8 | Expected detector identification byte |
| cfg_stereo_lo | input | 7 | Stereo range lower bound |
| cfg_stereo_hi | input | 7 | Stereo range upper bound |
| cfg_axial_lo | input | 7 | Axial range lower bound |
| cfg_axial_hi | input | 7 | Axial range upper bound |
| cfg_z_lo | input | 7 | Z range lower bound |
| cfg_z_hi | input | 7 | Z range upper bound |
| tbl_we | input | 1 | Table write strobe |
| tbl_sel | input | 2 | Table select: 0 gain, 1 offset, 2 bad-channel map |
| tbl_addr | input | 11 | Table address |
| tbl_wdata | input | 8 | Table write data |
| out_valid | output | 1 | Output word valid |
| out_word | output | 23 | Tagged hit word |
| err_hdr_cnt | output | 8 | Identification mismatch count, saturating |
| err_zero_cnt | output | 8 | Missing zero byte count, saturating |

## Verification
The properties assume that `in_byte` is stable and meaningful whenever `in_valid` is high. They also assume that the configuration ports stay constant within an event, since the bounds and expected IDs are sampled at the moment each byte is used. The stimulus changes inputs only on the falling clock edge. It programs the configuration and tables before the first byte and never changes them afterwards. The only overlap of a table write with `in_valid` is the deliberate stall case.

// File: rtl/strip_pkg.sv
package strip_pkg;
    localparam int CHIP_W    = 4;
    localparam int CHAN_W    = 7;
    localparam int DATA_W    = 8;
    localparam int NUM_W     = DATA_W - 1;
    localparam int MAP_AW    = CHIP_W + CHAN_W;
    localparam int NCHIPS    = 1 << CHIP_W;
    localparam int MAP_DEPTH = 1 << MAP_AW;
    localparam int NRANGES   = 3;
    localparam logic [DATA_W-1:0] EOE_CODE = 8'hC0;

    typedef enum logic [2:0] {
        ST_SEQ, ST_DET, ST_CHIP, ST_ZERO, ST_ADDR, ST_DATA, ST_EVT
    } pstate_e;

    typedef enum logic [1:0] {
        TY_NONE   = 2'b00,
        TY_STEREO = 2'b01,
        TY_AXIAL  = 2'b10,
        TY_Z      = 2'b11
    } stype_e;

    typedef enum logic [1:0] {
        TBL_GAIN   = 2'd0,
        TBL_OFFSET = 2'd1,
        TBL_BADMAP = 2'd2
    } tbl_e;

    typedef struct packed {
        stype_e              kind;
        logic                fresh;
        logic                eoe;
        logic [DATA_W-1:0]   value;
        logic [CHIP_W-1:0]   chip;
        logic [CHAN_W-1:0]   chan;
    } hit_word_t;

    localparam int WORD_W = $bits(hit_word_t);
endpackage

// File: rtl/strip_type_class.sv
module strip_type_class
    import strip_pkg::*;
(
    input  logic [NUM_W-1:0]         chip_num,
    input  logic [NRANGES*NUM_W-1:0] lo_bounds,
    input  logic [NRANGES*NUM_W-1:0] hi_bounds,
    output stype_e                   kind
);
    logic [NRANGES-1:0] in_rng;

    for (genvar r = 0; r < NRANGES; r++) begin : g_rng
        assign in_rng[r] = (chip_num >= lo_bounds[r*NUM_W +: NUM_W]) &&
                           (chip_num <= hi_bounds[r*NUM_W +: NUM_W]);
    end

    // lowest index wins: stereo, then axial, then z
    always_comb begin
        if (in_rng[0])      kind = TY_STEREO;
        else if (in_rng[1]) kind = TY_AXIAL;
        else if (in_rng[2]) kind = TY_Z;
        else                kind = TY_NONE;
    end
endmodule

// File: rtl/strip_cal_store.sv
module strip_cal_store
    import strip_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [MAP_AW-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [CHIP_W-1:0] rd_chip,
    input  logic [MAP_AW-1:0] rd_map_addr,
    output logic [DATA_W-1:0] rd_gain,
    output logic [DATA_W-1:0] rd_offset,
    output logic              rd_bad
);
    logic [DATA_W-1:0]    gain_q   [NCHIPS];
    logic [DATA_W-1:0]    offset_q [NCHIPS];
    logic [MAP_DEPTH-1:0] badmap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NCHIPS; i++) begin
                gain_q[i]   <= DATA_W'(1);
                offset_q[i] <= '0;
            end
            badmap_q <= '0;
        end else if (wr_en) begin
            case (wr_sel)
                TBL_GAIN:   gain_q[wr_addr[CHIP_W-1:0]]   <= wr_data;
                TBL_OFFSET: offset_q[wr_addr[CHIP_W-1:0]] <= wr_data;
                TBL_BADMAP: badmap_q[wr_addr]             <= wr_data[0];
                default: ;
            endcase
        end
    end

    assign rd_gain   = gain_q[rd_chip];
    assign rd_offset = offset_q[rd_chip];
    assign rd_bad    = badmap_q[rd_map_addr];
endmodule

// File: rtl/strip_correct.sv
module strip_correct
    import strip_pkg::*;
(
    input  logic [DATA_W-1:0] raw,
    input  logic [DATA_W-1:0] gain,
    input  logic [DATA_W-1:0] offset,
    input  logic              bad,
    output logic [DATA_W-1:0] value
);
    localparam int SUM_W = 2*DATA_W + 1;
    localparam logic [SUM_W-1:0] MAXV = SUM_W'({DATA_W{1'b1}});

    logic [SUM_W-1:0] sum;

    always_comb begin
        sum = SUM_W'(raw) * SUM_W'(gain) + SUM_W'(offset);
        if (bad)             value = '0;
        else if (sum > MAXV) value = '1;
        else                 value = sum[DATA_W-1:0];
    end
endmodule

// File: rtl/strip_parser.sv
module strip_parser
    import strip_pkg::*;
#(
    parameter int ERR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [7:0]        in_byte,
    output logic              in_ready,
    input  logic [7:0]        cfg_seq_id,
    input  logic [7:0]        cfg_det_id,
    input  logic [6:0]        cfg_stereo_lo,
    input  logic [6:0]        cfg_stereo_hi,
    input  logic [6:0]        cfg_axial_lo,
    input  logic [6:0]        cfg_axial_hi,
    input  logic [6:0]        cfg_z_lo,
    input  logic [6:0]        cfg_z_hi,
    input  logic              tbl_we,
    input  logic [1:0]        tbl_sel,
    input  logic [10:0]       tbl_addr,
    input  logic [7:0]        tbl_wdata,
    output logic              out_valid,
    output logic [22:0]       out_word,
    output logic [ERR_W-1:0]  err_hdr_cnt,
    output logic [ERR_W-1:0]  err_zero_cnt
);
    typedef struct packed {
        pstate_e            st;
        logic [NUM_W-1:0]   chip;
        stype_e             kind;
        logic [CHAN_W-1:0]  chan;
        logic               fresh;
        logic               ovalid;
        hit_word_t          word;
        logic [ERR_W-1:0]   err_hdr;
        logic [ERR_W-1:0]   err_zero;
    } regs_t;

    regs_t q, d;

    logic              accept;
    stype_e            cls_kind;
    logic [DATA_W-1:0] gain, offset, corr;
    logic              bad;
    logic [MAP_AW-1:0] map_addr;
    logic [CHIP_W-1:0] chip_lo;

    function automatic logic [ERR_W-1:0] sat_inc(input logic [ERR_W-1:0] v);
        return (&v) ? v : v + 1'b1;
    endfunction

    assign in_ready = !tbl_we;
    assign accept   = in_valid && in_ready;
    assign chip_lo  = q.chip[CHIP_W-1:0];
    assign map_addr = {chip_lo - 1'b1, q.chan};

    strip_type_class u_class (
        .chip_num  (in_byte[NUM_W-1:0]),
        .lo_bounds ({cfg_z_lo, cfg_axial_lo, cfg_stereo_lo}),
        .hi_bounds ({cfg_z_hi, cfg_axial_hi, cfg_stereo_hi}),
        .kind      (cls_kind)
    );

    strip_cal_store u_store (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (tbl_we),
        .wr_sel      (tbl_sel),
        .wr_addr     (tbl_addr),
        .wr_data     (tbl_wdata),
        .rd_chip     (chip_lo),
        .rd_map_addr (map_addr),
        .rd_gain     (gain),
        .rd_offset   (offset),
        .rd_bad      (bad)
    );

    strip_correct u_corr (
        .raw    (in_byte),
        .gain   (gain),
        .offset (offset),
        .bad    (bad),
        .value  (corr)
    );

    always_comb begin
        d        = q;
        d.ovalid = 1'b0;
        if (accept) begin
            case (q.st)
                ST_SEQ: begin
                    if (in_byte != cfg_seq_id) d.err_hdr = sat_inc(q.err_hdr);
                    d.st = ST_DET;
                end
                ST_DET: begin
                    if (in_byte != cfg_det_id) d.err_hdr = sat_inc(q.err_hdr);
                    else                       d.fresh   = 1'b1;
                    d.st = ST_CHIP;
                end
                ST_CHIP: begin
                    if (in_byte[DATA_W-1]) begin
                        d.chip = in_byte[NUM_W-1:0];
                        d.kind = cls_kind;
                        d.st   = ST_ZERO;
                    end else begin
                        d.st = ST_SEQ;
                    end
                end
                ST_ZERO: begin
                    if (in_byte != '0) begin
                        d.err_zero = sat_inc(q.err_zero);
                        d.st       = ST_SEQ;
                    end else begin
                        d.st = ST_ADDR;
                    end
                end
                ST_ADDR: begin
                    if (!in_byte[DATA_W-1]) begin
                        d.chan = in_byte[CHAN_W-1:0];
                        d.st   = ST_DATA;
                    end else if (in_byte == EOE_CODE) begin
                        d.st = ST_EVT;
                    end else begin
                        d.st = ST_CHIP;
                    end
                end
                ST_DATA: begin
                    d.ovalid     = 1'b1;
                    d.word.kind  = q.kind;
                    d.word.fresh = q.fresh;
                    d.word.eoe   = 1'b0;
                    d.word.value = corr;
                    d.word.chip  = chip_lo;
                    d.word.chan  = q.chan;
                    d.fresh      = 1'b0;
                    d.st         = ST_ADDR;
                end
                ST_EVT: begin
                    d.ovalid     = 1'b1;
                    d.word.kind  = q.kind;
                    d.word.fresh = q.fresh;
                    d.word.eoe   = 1'b1;
                    d.word.value = in_byte;
                    d.word.chip  = chip_lo;
                    d.word.chan  = q.chan;
                    d.st         = ST_SEQ;
                end
                default: d.st = ST_SEQ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign out_valid    = q.ovalid;
    assign out_word     = q.word;
    assign err_hdr_cnt  = q.err_hdr;
    assign err_zero_cnt = q.err_zero;
endmodule

// File: rtl/strip_parser_chk.sv
module strip_parser_chk
    import strip_pkg::*;
#(
    parameter int ERR_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic [7:0]       in_byte,
    input logic             tbl_we,
    input logic             out_valid,
    input logic [22:0]      out_word,
    input logic [ERR_W-1:0] err_hdr_cnt,
    input logic [ERR_W-1:0] err_zero_cnt
);
    hit_word_t w;
    assign w = hit_word_t'(out_word);

    // R12
    out_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid && in_ready));

    // R12
    no_out_after_load_chk: assert property (@(posedge clk) disable iff (rst)
        tbl_we |=> !out_valid);

    // R1
    hdr_err_step_chk: assert property (@(posedge clk) disable iff (rst)
        (err_hdr_cnt != $past(err_hdr_cnt)) |-> (err_hdr_cnt == $past(err_hdr_cnt) + 1'b1));

    // R3
    zero_err_step_chk: assert property (@(posedge clk) disable iff (rst)
        (err_zero_cnt != $past(err_zero_cnt)) |-> (err_zero_cnt == $past(err_zero_cnt) + 1'b1));

    // R3
    err_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        (err_hdr_cnt != $past(err_hdr_cnt)) |-> $stable(err_zero_cnt));

    // R1
    err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && in_ready) |=> ($stable(err_hdr_cnt) && $stable(err_zero_cnt)));

    // R8
    eoe_echo_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && w.eoe) |-> (w.value == $past(in_byte)));
endmodule

bind strip_parser strip_parser_chk #(.ERR_W(ERR_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .in_byte      (in_byte),
    .tbl_we       (tbl_we),
    .out_valid    (out_valid),
    .out_word     (out_word),
    .err_hdr_cnt  (err_hdr_cnt),
    .err_zero_cnt (err_zero_cnt)
);

// File: tb/strip_parser_bench.sv
`timescale 1ns/1ps
module strip_parser_bench;
    localparam int CYC = 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        in_ready;
    logic        tbl_we = 1'b0;
    logic [1:0]  tbl_sel = 2'd0;
    logic [10:0] tbl_addr = '0;
    logic [7:0]  tbl_wdata = '0;
    logic        out_valid;
    logic [22:0] out_word;
    logic [7:0]  err_hdr_cnt, err_zero_cnt;

    localparam logic [7:0] SEQ = 8'h5A;
    localparam logic [7:0] DET = 8'h3C;

    int n_checks = 0;
    int n_fail   = 0;
    logic [22:0] exp_q[$];
    string       tag_q[$];

    always #(CYC/2) clk = ~clk;

    strip_parser u_strip_parser (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte), .in_ready(in_ready),
        .cfg_seq_id(SEQ), .cfg_det_id(DET),
        .cfg_stereo_lo(7'd0), .cfg_stereo_hi(7'd3),
        .cfg_axial_lo(7'd2),  .cfg_axial_hi(7'd7),
        .cfg_z_lo(7'd8),      .cfg_z_hi(7'd11),
        .tbl_we(tbl_we), .tbl_sel(tbl_sel), .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata),
        .out_valid(out_valid), .out_word(out_word),
        .err_hdr_cnt(err_hdr_cnt), .err_zero_cnt(err_zero_cnt)
    );

    // R11 layout: type[22:21] new[20] eof[19] data[18:11] chip[10:7] channel[6:0]
    function automatic logic [22:0] mk(input logic [1:0] t, input logic n, input logic e,
                                       input logic [7:0] v, input logic [3:0] c, input logic [6:0] ch);
        return {t, n, e, v, c, ch};
    endfunction

    // R5: gain = chip+1, offset = 3*chip as loaded below, clamped at 255
    function automatic logic [7:0] corr(input int raw, input int chip);
        int s;
        s = raw * (chip + 1) + 3 * chip;
        return (s > 255) ? 8'd255 : 8'(s);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic expect_word(input string tag, input logic [22:0] w);
        exp_q.push_back(w);
        tag_q.push_back(tag);
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
        @(posedge clk);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic tbl_write(input logic [1:0] s, input int a, input int v);
        @(negedge clk);
        tbl_we    = 1'b1;
        tbl_sel   = s;
        tbl_addr  = 11'(a);
        tbl_wdata = 8'(v);
        @(posedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // monitor: compare each produced word against the scoreboard
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (exp_q.size() == 0) begin
                n_checks++;
                n_fail++;
                $display("FAIL R12 unexpected word actual=%h expected=none", out_word);
            end else begin
                automatic logic [22:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(t, 32'(out_word), 32'(e));
            end
        end
    end

    initial begin
        #(CYC * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R12 reset state
        check("R12 reset out_valid", 32'(out_valid), 32'd0);
        check("R12 reset err_hdr", 32'(err_hdr_cnt), 32'd0);
        check("R12 reset err_zero", 32'(err_zero_cnt), 32'd0);
        check("R12 reset in_ready", 32'(in_ready), 32'd1);

        // R12: a byte offered during a table write must not be consumed
        @(negedge clk);
        tbl_we = 1'b1; tbl_sel = 2'd0; tbl_addr = 11'd1; tbl_wdata = 8'd2;
        in_valid = 1'b1; in_byte = 8'h77;
        #1 check("R12 stall in_ready", 32'(in_ready), 32'd0);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        tbl_we = 1'b0;
        check("R12 stalled byte ignored err_hdr", 32'(err_hdr_cnt), 32'd0);
        check("R12 stalled byte no output", 32'(out_valid), 32'd0);

        // R13 table load
        for (int c = 0; c < 16; c++) begin
            tbl_write(2'd0, c, c + 1);
            tbl_write(2'd1, c, 3 * c);
        end
        tbl_write(2'd2, 1 * 128 + 5, 1);   // chip 2, channel 5
        tbl_write(2'd2, 15 * 128 + 9, 1);  // chip 0 wraps to row 15, channel 9
        @(negedge clk);
        tbl_we = 1'b0;

        // R4 R7 R9 R8: chip 1 stereo, two hits, end of event
        send(SEQ); send(DET); send(8'h81); send(8'h00);
        send(8'd10); expect_word("R4 R9 chip1 first hit", mk(2'b01, 1, 0, corr(20, 1), 4'd1, 7'd10)); send(8'd20);
        send(8'd11); expect_word("R9 R5 chip1 second hit", mk(2'b01, 0, 0, corr(7, 1), 4'd1, 7'd11)); send(8'd7);
        send(8'hC0); expect_word("R8 R11 eoe chip1", mk(2'b01, 0, 1, 8'h44, 4'd1, 7'd11)); send(8'h44);
        idle();

        // R5 R7: chip 5 axial, saturation, exact 255, channel 127
        send(SEQ); send(DET); send(8'h85); send(8'h00);
        send(8'd3); expect_word("R5 saturate 200", mk(2'b10, 1, 0, 8'd255, 4'd5, 7'd3)); send(8'd200);
        send(8'd4); expect_word("R5 exact 255", mk(2'b10, 0, 0, 8'd255, 4'd5, 7'd4)); send(8'd40);
        send(8'd127); expect_word("R4 channel 127", mk(2'b10, 0, 0, corr(0, 5), 4'd5, 7'd127)); send(8'd0);
        send(8'hC0); expect_word("R8 eoe chip5", mk(2'b10, 0, 1, 8'h01, 4'd5, 7'd127)); send(8'h01);
        idle();

        // R6 R7: chip 2 in stereo/axial overlap, bad channel 5
        send(SEQ); send(DET); send(8'h82); send(8'h00);
        send(8'd5); expect_word("R6 bad channel chip2", mk(2'b01, 1, 0, 8'd0, 4'd2, 7'd5)); send(8'd10);
        send(8'd6); expect_word("R7 overlap priority", mk(2'b01, 0, 0, corr(10, 2), 4'd2, 7'd6)); send(8'd10);
        send(8'hC0); expect_word("R8 eoe chip2", mk(2'b01, 0, 1, 8'h02, 4'd2, 7'd6)); send(8'h02);
        idle();

        // R1 R9 R7: both ID bytes wrong, chip 12 outside all ranges
        send(8'h11); send(8'h22); send(8'h8C); send(8'h00);
        send(8'd1); expect_word("R1 R7 no-range chip12", mk(2'b00, 0, 0, corr(2, 12), 4'd12, 7'd1)); send(8'd2);
        send(8'hC0); expect_word("R8 eoe chip12", mk(2'b00, 0, 1, 8'h03, 4'd12, 7'd1)); send(8'h03);
        idle();
        check("R1 err_hdr after two mismatches", 32'(err_hdr_cnt), 32'd2);
        check("R1 err_zero unchanged", 32'(err_zero_cnt), 32'd0);

        // R10 R7: chip 8 z, address byte 0x90 goes back to chip header, chip 9
        send(SEQ); send(DET); send(8'h88); send(8'h00);
        send(8'd0); expect_word("R7 z chip8", mk(2'b11, 1, 0, corr(1, 8), 4'd8, 7'd0)); send(8'd1);
        send(8'h90); send(8'h89); send(8'h00);
        send(8'd2); expect_word("R10 rechip chip9", mk(2'b11, 0, 0, corr(1, 9), 4'd9, 7'd2)); send(8'd1);
        send(8'hC0); expect_word("R8 eoe chip9", mk(2'b11, 0, 1, 8'h05, 4'd9, 7'd2)); send(8'h05);
        idle();

        // R3 R2 R6: bad zero byte, low chip byte, then chip 0 wrap into map row 15
        send(SEQ); send(DET); send(8'h81); send(8'h07);
        idle();
        check("R3 err_zero", 32'(err_zero_cnt), 32'd1);
        send(SEQ); send(DET); send(8'h10);
        send(SEQ); send(DET); send(8'h80); send(8'h00);
        send(8'd9); expect_word("R6 R2 chip0 wrap bad", mk(2'b01, 1, 0, 8'd0, 4'd0, 7'd9)); send(8'd50);
        send(8'd10); expect_word("R2 chip0 good", mk(2'b01, 0, 0, corr(50, 0), 4'd0, 7'd10)); send(8'd50);
        send(8'hC0); expect_word("R8 eoe chip0", mk(2'b01, 0, 1, 8'h06, 4'd0, 7'd10)); send(8'h06);
        idle();
        check("R2 err_hdr unchanged", 32'(err_hdr_cnt), 32'd2);
        check("R3 err_zero final", 32'(err_zero_cnt), 32'd1);

        repeat (4) @(negedge clk);
        check("R12 all expected words seen", 32'(exp_q.size()), 32'd0);
        finish_run();
    end
endmodule